// File: doc/BRIEF.md
# Bus Controller Control/Status Register File with Set and Clear Aliases

This block is the register file of a serial-bus controller. It holds a command word, three timing words and an interrupt word. Each word can be reached at three addresses. The base address replaces the contents. The address four bytes higher ORs in the bits written as one. The address eight bytes higher clears the bits written as one. Software can therefore change single bits without a read-modify-write sequence.

The interrupt word combines eight status flags with their eight enables. Each enable sits eight bit positions above its flag. The bus engine sets a flag with a one-cycle event strobe, and software clears it through the clear alias. The block drives a level interrupt and a two-bit error class decoded from the flags. The top bit of the command word is a soft reset that cleans the whole file and then clears itself.

Requests come over a simple valid/write/address/data bus. Read data is registered.

Top module: `busctl_csr`

## Requirements
- R1: The command word sits at offset 0x00, the timing words at 0x10, 0x20 and 0x30, and the interrupt word at 0x40. A write to the base offset of the command or a timing word replaces all 32 bits, and the new value appears on that word's output port one cycle later. A base write to the interrupt word loads only the enables, in bits 15:8.
- R2: A write to base+0x04 ORs the written ones into the word and leaves the other bits as they were. On the interrupt word this acts on the enables only.
- R3: A write to base+0x08 clears every bit written as one and keeps the rest. On the interrupt word it clears flags in bits 7:0 and enables in bits 15:8.
- R4: A read request returns data on `rsp_rdata` in the next cycle, and the value is held until the next read. Reading base+0x04 or base+0x08 returns the same value as the base offset. Bits 31:16 of the interrupt word read as zero.
- R5: Any offset other than base, base+0x04 or base+0x08 of the five words reads as zero. Writes to such an offset change no register.
- R6: An event strobe on bit i sets flag i in the cycle after the strobe. The flag stays set until it is cleared. Base and SET writes to the interrupt word never alter the flags.
- R7: If an event strobe and a clear-alias write of one to the same flag fall in the same cycle, the flag ends up set.
- R8: `irq_out` is high exactly while some flag i is set together with its enable i+8.
- R9: `err_kind` is 2'b01 (no device) while flag 5 is set, regardless of the other flags. It is 2'b10 (I/O error) while flag 5 is clear and any of flags 3..0 is set. It is 2'b00 otherwise. Flags 7, 6 and 4 never produce an error class.
- R10: Writing one to bit 31 of the command word, through the base or the SET alias, has the following effect one cycle later: every register is zero except command bit 31, which reads as one. In the cycle after that, bit 31 returns to zero. Writes and event strobes that arrive while bit 31 is one are ignored.
- R11: After the asynchronous reset, every register, the read data, `irq_out` and `err_kind` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the request |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Registered read data |
| evt_strobe | input | NUM_FLAGS | One-cycle event strobes from the bus engine |
| cmd_word | output | DATA_W | Current command word |
| tim0_word | output | DATA_W | Timing word 0 |
| tim1_word | output | DATA_W | Timing word 1 |
| tim2_word | output | DATA_W | Timing word 2 |
| irq_out | output | 1 | Level interrupt |
| err_kind | output | 2 | Decoded error class |

## Verification
Writes, event strobes and read data all become visible one clock edge after the cycle in which they are presented. The interrupt level and the error class follow the flag registers with no further delay, so they are due at that same edge. The soft reset spans two edges: the clean state with bit 31 set appears after the first edge, and bit 31 is gone after the second. The bench drives requests on the falling edge and advances a behavioural model on the rising edge. It compares every output on the next falling edge, so each result is checked exactly in its due cycle.

// File: rtl/busctl_csr_pkg.sv
package busctl_csr_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_BASE = 2'd1,
    ACC_SET  = 2'd2,
    ACC_CLR  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_NODEV = 2'd1,
    ERR_IO    = 2'd2
  } err_e;

  localparam logic [3:0]  SUB_BASE  = 4'h0;
  localparam logic [3:0]  SUB_SET   = 4'h4;
  localparam logic [3:0]  SUB_CLR   = 4'h8;
  localparam int unsigned NUM_PLAIN = 4;              // command + three timing words
  localparam int unsigned IRQ_IDX   = NUM_PLAIN;      // interrupt word index
  localparam int unsigned NUM_WORDS = NUM_PLAIN + 1;

endpackage

// File: rtl/busctl_csr_decode.sv
module busctl_csr_decode
  import busctl_csr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WORDS     = NUM_WORDS
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [WORDS-1:0]  sel,
  output acc_e              acc,
  output logic              wr_en,
  output logic              rd_en
);

  localparam int unsigned IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] idx;
  logic             hit;

  always_comb begin
    idx = req_addr[ADDR_W-1:4];
    unique case (req_addr[3:0])
      SUB_BASE: acc = ACC_BASE;
      SUB_SET:  acc = ACC_SET;
      SUB_CLR:  acc = ACC_CLR;
      default:  acc = ACC_NONE;
    endcase
    hit = req_valid && (acc != ACC_NONE) && (idx < IDX_W'(WORDS));
    for (int i = 0; i < int'(WORDS); i++) begin
      sel[i] = hit && (idx == IDX_W'(i));
    end
    wr_en = hit && req_write;
    rd_en = req_valid && !req_write;
  end

endmodule

// File: rtl/busctl_csr_word.sv
module busctl_csr_word
  import busctl_csr_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  acc_e         acc,
  input  logic [W-1:0] wdata,
  input  logic         clear,
  input  logic [W-1:0] clear_val,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;
  logic         q_ld;
  logic [W-1:0] wbits;

  always_comb begin
    wbits = wdata & WMASK;
    q_ld  = clear || wr_en;
    q_nxt = q;
    if (clear) begin
      q_nxt = clear_val;
    end else if (wr_en) begin
      unique case (acc)
        ACC_BASE: q_nxt = (q & ~WMASK) | wbits;
        ACC_SET:  q_nxt = q | wbits;
        ACC_CLR:  q_nxt = q & ~wbits;
        default:  q_nxt = q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_ld) begin
      q <= q_nxt;
    end
  end

  // R2: set alias only adds ones
  p_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc == ACC_SET && !clear) |=> ((q & $past(q)) == $past(q)));

  // R3: clear alias only removes ones
  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc == ACC_CLR && !clear) |=> ((q & ~$past(q)) == '0));

endmodule

// File: rtl/busctl_csr_irq.sv
module busctl_csr_irq
  import busctl_csr_pkg::*;
#(
  parameter int unsigned NF         = 8,
  parameter int unsigned NODEV_BIT  = 5,
  parameter logic [NF-1:0] IO_MASK  = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  acc_e          acc,
  input  logic [2*NF-1:0] wdata,
  input  logic          clear,
  input  logic [NF-1:0] evt,
  output logic [NF-1:0] flags_q,
  output logic [NF-1:0] en_q,
  output logic          irq,
  output logic [1:0]    err
);

  logic [NF-1:0] flags_nxt;
  logic [NF-1:0] flag_clr;

  // enables use the generic aliased word
  busctl_csr_word #(.W(NF)) u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .acc       (acc),
    .wdata     (wdata[2*NF-1:NF]),
    .clear     (clear),
    .clear_val ('0),
    .q         (en_q)
  );

  always_comb begin
    flag_clr  = (wr_en && acc == ACC_CLR) ? wdata[NF-1:0] : '0;
    flags_nxt = clear ? '0 : ((flags_q & ~flag_clr) | evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_nxt;
    end
  end

  always_comb begin
    irq = |(flags_q & en_q);
    if (flags_q[NODEV_BIT]) begin
      err = ERR_NODEV;
    end else if (|(flags_q & IO_MASK)) begin
      err = ERR_IO;
    end else begin
      err = ERR_NONE;
    end
  end

  // R6: a flag only rises where an event strobe was seen
  p_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((flags_q & ~$past(flags_q) & ~$past(evt)) == '0));

  // R7: an event wins over a same-cycle clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt) && !clear) |=> ((flags_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/busctl_csr.sv
module busctl_csr
  import busctl_csr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned SRST_BIT  = DATA_W - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic [NUM_FLAGS-1:0] evt_strobe,
  output logic [DATA_W-1:0]    cmd_word,
  output logic [DATA_W-1:0]    tim0_word,
  output logic [DATA_W-1:0]    tim1_word,
  output logic [DATA_W-1:0]    tim2_word,
  output logic                 irq_out,
  output logic [1:0]           err_kind
);

  localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << SRST_BIT;

  logic [NUM_WORDS-1:0] sel;
  acc_e                 acc;
  logic                 wr_en;
  logic                 rd_en;
  logic [DATA_W-1:0]    word_q [NUM_PLAIN];
  logic [NUM_FLAGS-1:0] flags_q;
  logic [NUM_FLAGS-1:0] en_q;
  logic                 srst_pend;
  logic                 srst_req;
  logic                 srst_any;
  logic [DATA_W-1:0]    rd_mux;

  busctl_csr_decode #(.ADDR_W(ADDR_W), .WORDS(NUM_WORDS)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .sel       (sel),
    .acc       (acc),
    .wr_en     (wr_en),
    .rd_en     (rd_en)
  );

  // soft reset: request on a base/set write of the top bit, then one pending cycle
  always_comb begin
    srst_pend = word_q[0][SRST_BIT];
    srst_req  = wr_en && sel[0] && (acc == ACC_BASE || acc == ACC_SET)
                && req_wdata[SRST_BIT] && !srst_pend;
    srst_any  = srst_req || srst_pend;
  end

  for (genvar g = 0; g < int'(NUM_PLAIN); g++) begin : g_word
    logic [DATA_W-1:0] clr_val;
    if (g == 0) begin : g_cmd
      assign clr_val = srst_req ? SRST_MASK : '0;
    end else begin : g_tim
      assign clr_val = '0;
    end
    busctl_csr_word #(.W(DATA_W)) u_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en && sel[g]),
      .acc       (acc),
      .wdata     (req_wdata),
      .clear     (srst_any),
      .clear_val (clr_val),
      .q         (word_q[g])
    );
  end

  busctl_csr_irq #(.NF(NUM_FLAGS)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en && sel[IRQ_IDX]),
    .acc     (acc),
    .wdata   (req_wdata[2*NUM_FLAGS-1:0]),
    .clear   (srst_any),
    .evt     (evt_strobe),
    .flags_q (flags_q),
    .en_q    (en_q),
    .irq     (irq_out),
    .err     (err_kind)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < int'(NUM_PLAIN); i++) begin
      if (sel[i]) rd_mux = word_q[i];
    end
    if (sel[IRQ_IDX]) rd_mux = DATA_W'({en_q, flags_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (rd_en) begin
      rsp_rdata <= rd_mux;
    end
  end

  assign cmd_word  = word_q[0];
  assign tim0_word = word_q[1];
  assign tim1_word = word_q[2];
  assign tim2_word = word_q[3];

  // R10: pending soft reset leaves the whole file clean
  p_srst_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pend |=> (word_q[0] == '0 && word_q[1] == '0 && word_q[2] == '0
                   && word_q[3] == '0 && flags_q == '0 && en_q == '0));

  // R10: the soft-reset bit sets the clean state with only itself high
  p_srst_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |=> (word_q[0] == SRST_MASK && flags_q == '0 && en_q == '0));

  // R5: unmapped reads return zero
  p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == '0) |=> (rsp_rdata == '0));

endmodule

// File: tb/sim_busctl_csr.sv
`timescale 1ns/1ps
module sim_busctl_csr;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic [7:0]  evt_strobe;
  logic [31:0] cmd_word, tim0_word, tim1_word, tim2_word;
  logic        irq_out;
  logic [1:0]  err_kind;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  busctl_csr u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .evt_strobe(evt_strobe), .cmd_word(cmd_word), .tim0_word(tim0_word),
    .tim1_word(tim1_word), .tim2_word(tim2_word), .irq_out(irq_out),
    .err_kind(err_kind)
  );

  // behavioural reference
  logic [31:0] m_w [4];
  logic [7:0]  m_fl, m_en, m_clr;
  logic [31:0] m_rd;
  int          m_idx;
  logic [3:0]  m_sub;
  logic        m_hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_w[i] = 32'h0;
      m_fl = 8'h0; m_en = 8'h0; m_rd = 32'h0;
    end else begin
      m_idx = int'(req_addr[7:4]);
      m_sub = req_addr[3:0];
      m_hit = req_valid && (m_sub == 4'h0 || m_sub == 4'h4 || m_sub == 4'h8) && m_idx <= 4;
      if (req_valid && !req_write) begin
        if (!m_hit) m_rd = 32'h0;
        else if (m_idx == 4) m_rd = {16'h0, m_en, m_fl};
        else m_rd = m_w[m_idx];
      end
      if (m_w[0][31]) begin
        for (int i = 0; i < 4; i++) m_w[i] = 32'h0;
        m_fl = 8'h0; m_en = 8'h0;
      end else if (m_hit && req_write && m_idx == 0 && m_sub != 4'h8 && req_wdata[31]) begin
        for (int i = 0; i < 4; i++) m_w[i] = 32'h0;
        m_w[0] = 32'h8000_0000;
        m_fl = 8'h0; m_en = 8'h0;
      end else begin
        m_clr = 8'h0;
        if (m_hit && req_write) begin
          if (m_idx < 4) begin
            case (m_sub)
              4'h0: m_w[m_idx] = req_wdata;
              4'h4: m_w[m_idx] = m_w[m_idx] | req_wdata;
              default: m_w[m_idx] = m_w[m_idx] & ~req_wdata;
            endcase
          end else begin
            case (m_sub)
              4'h0: m_en = req_wdata[15:8];
              4'h4: m_en = m_en | req_wdata[15:8];
              default: begin
                m_en  = m_en & ~req_wdata[15:8];
                m_clr = req_wdata[7:0];
              end
            endcase
          end
        end
        m_fl = (m_fl & ~m_clr) | evt_strobe;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 cmd", cmd_word, m_w[0]);
      chk("R1 tim0", tim0_word, m_w[1]);
      chk("R1 tim1", tim1_word, m_w[2]);
      chk("R1 tim2", tim2_word, m_w[3]);
      chk("R4 rdata", rsp_rdata, m_rd);
      chk("R8 irq", {31'h0, irq_out}, {31'h0, |(m_fl & m_en)});
      chk("R9 err", {30'h0, err_kind},
          {30'h0, m_fl[5] ? 2'd1 : (|m_fl[3:0] ? 2'd2 : 2'd0)});
    end
  end

  task automatic drive(input logic v, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic [7:0] e);
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; evt_strobe = e;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, 1'b1, a, d, 8'h0);
  endtask
  task automatic rd(input logic [7:0] a);
    drive(1'b1, 1'b0, a, 32'h0, 8'h0);
  endtask
  task automatic idle();
    drive(1'b0, 1'b0, 8'h0, 32'h0, 8'h0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = 8'h0; req_wdata = 32'h0; evt_strobe = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // R11 reset state
    chk("R11 cmd", cmd_word, 32'h0);
    chk("R11 rdata", rsp_rdata, 32'h0);
    chk("R11 irq/err", {29'h0, irq_out, err_kind}, 32'h0);

    // R1 base writes
    wr(8'h00, 32'h0012_3456); wr(8'h10, 32'hA5A5_0001);
    wr(8'h20, 32'h0000_00F0); wr(8'h30, 32'h1234_5678); idle();
    chk("R1 cmd base", cmd_word, 32'h0012_3456);
    chk("R1 tim2 base", tim2_word, 32'h1234_5678);

    // R2 set alias, R3 clear alias
    wr(8'h04, 32'h0000_0F00); idle();
    chk("R2 set", cmd_word, 32'h0012_3F56);
    wr(8'h08, 32'h0000_0056); idle();
    chk("R3 clr", cmd_word, 32'h0012_3F00);

    // R4 alias reads
    rd(8'h04); idle();
    chk("R4 set-alias read", rsp_rdata, 32'h0012_3F00);
    rd(8'h38); idle();
    chk("R4 clr-alias read", rsp_rdata, 32'h1234_5678);

    // R5 unmapped offsets
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h50, 32'hFFFF_FFFF); idle();
    chk("R5 no write cmd", cmd_word, 32'h0012_3F00);
    chk("R5 no write tim0", tim0_word, 32'hA5A5_0001);
    rd(8'h0C); idle();
    chk("R5 read zero", rsp_rdata, 32'h0);
    rd(8'h50); idle();
    chk("R5 read zero hi", rsp_rdata, 32'h0);

    // R6 events, base write touches enables only
    drive(1'b0, 1'b0, 8'h0, 32'h0, 8'h24); idle();
    chk("R9 nodev priority", {30'h0, err_kind}, 32'd1);
    chk("R8 no enable", {31'h0, irq_out}, 32'h0);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40); idle();
    chk("R6 flags kept, R4 upper zero", rsp_rdata, 32'h0000_FF24);
    chk("R8 enabled", {31'h0, irq_out}, 32'h1);

    // R9 error classes
    wr(8'h48, 32'h0000_0020); idle();
    chk("R9 io", {30'h0, err_kind}, 32'd2);
    wr(8'h48, 32'h0000_0004); drive(1'b0, 1'b0, 8'h0, 32'h0, 8'hD0); idle();
    chk("R9 none for 7/6/4", {30'h0, err_kind}, 32'd0);

    // R8 enable masking
    wr(8'h48, 32'h0000_FF00); idle();
    chk("R8 masked", {31'h0, irq_out}, 32'h0);
    wr(8'h44, 32'h0000_1000); idle();
    chk("R8 bit4 enabled", {31'h0, irq_out}, 32'h1);

    // R7 set wins over clear
    drive(1'b1, 1'b1, 8'h48, 32'h0000_0010, 8'h10); rd(8'h40); idle();
    chk("R7 set wins", rsp_rdata, 32'h0000_10D0);
    wr(8'h48, 32'h0000_00FF); idle();
    chk("R3 flags cleared", {31'h0, irq_out}, 32'h0);

    // R10 soft reset
    drive(1'b0, 1'b0, 8'h0, 32'h0, 8'h02);
    wr(8'h04, 32'h8000_0000);
    @(negedge clk);
    chk("R10 entry", cmd_word, 32'h8000_0000);
    chk("R10 tim cleared", tim0_word, 32'h0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10;
    req_wdata = 32'h0000_0055; evt_strobe = 8'h01;
    idle();
    chk("R10 bit31 self-clears", cmd_word, 32'h0);
    chk("R10 write ignored", tim0_word, 32'h0);
    rd(8'h40); idle();
    chk("R10 flags ignored", rsp_rdata, 32'h0);

    repeat (3) idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule